// File: doc/BRIEF.md
# Fetch-Execute Bus-Transfer Controller

This block sequences a small 8-bit machine whose every instruction is one transfer on a shared byte-wide bus. It alternates between two phases. In the fetch phase it puts its 16-bit program counter on the memory address. It latches the returned 16-bit word, high byte as the instruction and low byte as an immediate. It then advances the counter. In the execute phase it splits the instruction into two nibbles. The upper nibble picks the unit that drives the bus and the lower nibble picks the unit that takes the bus value. Each nibble is expanded into one-hot enable lines.

The arithmetic unit, the memory array and the I/O modules sit outside. They respond to the source enables and destination strobes. Three destination codes belong to the controller itself: two load the high and low jump-target bytes from the bus, and one performs a conditional jump. The conditional jump presets the counter from those bytes when the jump-condition input is true.

Top module: `fe_bus_ctrl`

## Requirements
- R1: The phase toggles on every clock edge outside reset, so each instruction takes exactly two cycles; `fetch_phase` is 1 during fetch.
- R2: During fetch, `mem_addr` equals the program counter.
- R3: At the end of fetch, `mem_rdata[15:8]` is latched as the instruction and `mem_rdata[7:0]` as the immediate, which is presented on `imm_out` from the next cycle.
- R4: The program counter increments by one at the end of every fetch, wrapping from 0xFFFF to 0x0000.
- R5: During execute, `src_en` has exactly one bit set, at the index given by instruction bits 7:4.
- R6: During execute, `dst_ld` has exactly one bit set, at the index given by instruction bits 3:0.
- R7: During fetch, `src_en` and `dst_ld` are all zero.
- R8: An execute with destination code 0xE loads the jump-high byte from `bus_in`; destination code 0xD loads the jump-low byte from `bus_in`.
- R9: An execute with destination code 0xF while `jump_cond` is 1 sets the counter to {jump-high, jump-low}, and that address is fetched next.
- R10: An execute with destination code 0xF while `jump_cond` is 0 leaves the counter at its already-incremented value.
- R11: Synchronous active-high reset clears the counter, instruction, immediate and jump bytes to zero and makes the next cycle a fetch, overriding any increment or jump in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| jump_cond | input | 1 | Condition flag for the conditional jump |
| mem_rdata | input | 16 | Memory word returned for the fetch address |
| bus_in | input | 8 | Current value of the shared data bus |
| mem_addr | output | 16 | Memory address (program counter) |
| fetch_phase | output | 1 | 1 in fetch, 0 in execute |
| imm_out | output | 8 | Latched immediate byte |
| src_en | output | 16 | One-hot bus-source enables |
| dst_ld | output | 16 | One-hot destination load strobes |

## Verification
The counter has two writers: the increment at the end of fetch and the preset at the end of a conditional jump. Reset can land on either of them. The bench takes the counter through a taken jump to 0xFFFF and its wrap to zero, and through untaken jumps. It also raises reset at random points, some of them on a jump execute and some on a fetch. A behavioural model decides each time whether increment, preset or reset wins, and the address, phase, immediate and one-hot lines are compared with it on every cycle.

// File: rtl/fe_ctrl_pkg.sv
package fe_ctrl_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int NIB_W  = 4;
    localparam int LINES  = 1 << NIB_W;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [NIB_W-1:0] src;
        logic [NIB_W-1:0] dst;
    } instr_t;

    localparam logic [NIB_W-1:0] DST_JLO  = 4'hD;
    localparam logic [NIB_W-1:0] DST_JHI  = 4'hE;
    localparam logic [NIB_W-1:0] DST_JUMP = 4'hF;

    function automatic logic [ADDR_W-1:0] join_target(
        input logic [BYTE_W-1:0] hi,
        input logic [BYTE_W-1:0] lo
    );
        return {hi, lo};
    endfunction

endpackage

// File: rtl/fe_phase_seq.sv
module fe_phase_seq
    import fe_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_FETCH;
        else
            phase <= (phase == PH_FETCH) ? PH_EXEC : PH_FETCH;
    end

    p_fetch_to_exec_r1: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FETCH |=> phase == PH_EXEC);
    p_exec_to_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        phase == PH_EXEC |=> phase == PH_FETCH);

endmodule

// File: rtl/fe_pc.sv
module fe_pc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] target,
    output logic [W-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (load)
            pc <= target;
        else if (inc)
            pc <= pc + 1'b1;
    end

    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> pc == '0);
    p_increment_r4: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> pc == $past(pc) + 1'b1);
    p_preset_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> pc == $past(target));

endmodule

// File: rtl/fe_nib_decode.sv
module fe_nib_decode #(
    parameter int SEL_W = 4,
    localparam int N_OUT = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [N_OUT-1:0] lines
);

    for (genvar i = 0; i < N_OUT; i++) begin : g_line
        assign lines[i] = en && (sel == SEL_W'(i));
    end

    p_one_active_r5: assert property (@(posedge clk) disable iff (rst)
        en |-> $countones(lines) == 1);
    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        !en |-> lines == '0);

endmodule

// File: rtl/fe_bus_ctrl.sv
module fe_bus_ctrl
    import fe_ctrl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W,
    parameter int NW = NIB_W,
    localparam int MW = 2 * BW,
    localparam int NL = 1 << NW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          jump_cond,
    input  logic [MW-1:0] mem_rdata,
    input  logic [BW-1:0] bus_in,
    output logic [AW-1:0] mem_addr,
    output logic          fetch_phase,
    output logic [BW-1:0] imm_out,
    output logic [NL-1:0] src_en,
    output logic [NL-1:0] dst_ld
);

    phase_e        phase;
    instr_t        ir;
    logic [BW-1:0] dr;
    logic [BW-1:0] jmp_hi;
    logic [BW-1:0] jmp_lo;
    logic [AW-1:0] pc;
    logic          in_exec;
    logic          take_jump;

    fe_phase_seq u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    assign in_exec     = (phase == PH_EXEC);
    assign fetch_phase = (phase == PH_FETCH);

    // Fetch latch: upper byte is the instruction, lower byte the immediate.
    always_ff @(posedge clk) begin
        if (rst) begin
            ir <= '0;
            dr <= '0;
        end else if (fetch_phase) begin
            ir <= instr_t'(mem_rdata[MW-1:BW]);
            dr <= mem_rdata[BW-1:0];
        end
    end

    fe_nib_decode #(.SEL_W(NW)) u_src_dec (
        .clk   (clk),
        .rst   (rst),
        .en    (in_exec),
        .sel   (ir.src),
        .lines (src_en)
    );

    fe_nib_decode #(.SEL_W(NW)) u_dst_dec (
        .clk   (clk),
        .rst   (rst),
        .en    (in_exec),
        .sel   (ir.dst),
        .lines (dst_ld)
    );

    // Jump target bytes are ordinary bus destinations.
    always_ff @(posedge clk) begin
        if (rst) begin
            jmp_hi <= '0;
            jmp_lo <= '0;
        end else begin
            if (dst_ld[DST_JHI]) jmp_hi <= bus_in;
            if (dst_ld[DST_JLO]) jmp_lo <= bus_in;
        end
    end

    assign take_jump = dst_ld[DST_JUMP] && jump_cond;

    fe_pc #(.W(AW)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .inc    (fetch_phase),
        .load   (take_jump),
        .target (join_target(jmp_hi, jmp_lo)),
        .pc     (pc)
    );

    assign mem_addr = pc;
    assign imm_out  = dr;

    p_untaken_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (dst_ld[DST_JUMP] && !jump_cond) |=> pc == $past(pc));
    p_jhi_load_r8: assert property (@(posedge clk) disable iff (rst)
        dst_ld[DST_JHI] |=> jmp_hi == $past(bus_in));
    p_dst_tracks_ir_r6: assert property (@(posedge clk) disable iff (rst)
        in_exec |-> dst_ld[ir.dst] && src_en[ir.src]);

endmodule

// File: tb/tb_fe_bus_ctrl.sv
module tb_fe_bus_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst;
    logic        jump_cond;
    logic [15:0] mem_rdata;
    logic [7:0]  bus_in;
    logic [15:0] mem_addr;
    logic        fetch_phase;
    logic [7:0]  imm_out;
    logic [15:0] src_en;
    logic [15:0] dst_ld;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference state
    bit          m_exec;
    logic [15:0] m_pc;
    logic [7:0]  m_ir, m_dr, m_jh, m_jl;

    always #(CLK_PERIOD/2) clk = ~clk;

    fe_bus_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .jump_cond   (jump_cond),
        .mem_rdata   (mem_rdata),
        .bus_in      (bus_in),
        .mem_addr    (mem_addr),
        .fetch_phase (fetch_phase),
        .imm_out     (imm_out),
        .src_en      (src_en),
        .dst_ld      (dst_ld)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        case (a)
            16'h0000: return 16'h1EFF;  // jump-high <- FF
            16'h0001: return 16'h1DFF;  // jump-low  <- FF
            16'h0002: return 16'h1F00;  // jump to FFFF
            16'h0003: return 16'h1E00;
            16'h0004: return 16'h1D10;
            16'h0005: return 16'h1F00;  // jump to 0010
            16'h0010: return 16'h23A7;
            16'h0011: return 16'h9F00;
            default:  return {a[7:0] ^ 8'h5A, a[15:8] ^ 8'h3C};
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [15:0] e_src, e_dst;
        e_src = m_exec ? (16'h1 << m_ir[7:4]) : 16'h0;   // R5, R7
        e_dst = m_exec ? (16'h1 << m_ir[3:0]) : 16'h0;   // R6, R7
        check("R1 fetch_phase", {15'b0, fetch_phase}, {15'b0, !m_exec});
        check("R2 R4 R9 R10 R11 mem_addr", mem_addr, m_pc);
        check("R3 imm_out", {8'b0, imm_out}, {8'b0, m_dr});
        check("R5 R7 src_en", src_en, e_src);
        check("R6 R7 dst_ld", dst_ld, e_dst);
    endtask

    // Apply one clock edge to the model with the inputs present at that edge.
    task automatic model_edge();
        if (rst) begin                                   // R11
            m_exec = 1'b0; m_pc = 16'h0;
            m_ir = 8'h0; m_dr = 8'h0; m_jh = 8'h0; m_jl = 8'h0;
        end else if (!m_exec) begin                      // R3, R4
            m_ir = mem_rdata[15:8];
            m_dr = mem_rdata[7:0];
            m_pc = m_pc + 16'h1;
            m_exec = 1'b1;
        end else begin
            if (m_ir[3:0] == 4'hE) m_jh = bus_in;        // R8
            if (m_ir[3:0] == 4'hD) m_jl = bus_in;        // R8
            if (m_ir[3:0] == 4'hF && jump_cond)          // R9 (R10 when flag low)
                m_pc = {m_jh, m_jl};
            m_exec = 1'b0;
        end
    endtask

    task automatic cycle();
        mem_rdata = mem_word(mem_addr);
        if (m_exec && m_ir[7:4] == 4'h1) bus_in = m_dr;
        else bus_in = 8'($urandom);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        rst = 1'b1; jump_cond = 1'b1; mem_rdata = 16'h0; bus_in = 8'h0;
        m_exec = 1'b0; m_pc = 16'h0;
        m_ir = 8'h0; m_dr = 8'h0; m_jh = 8'h0; m_jl = 8'h0;
        @(negedge clk);
        cycle();
        cycle();
        rst = 1'b0;
        // Directed: taken jump to FFFF, wrap to 0000 (R4, R9)
        for (int i = 0; i < 40; i++) cycle();
        // Untaken jumps from the directed program (R10)
        rst = 1'b1; cycle(); rst = 1'b0;
        jump_cond = 1'b0;
        for (int i = 0; i < 14; i++) cycle();
        // Random flag and random reset, including reset on jump and fetch (R11)
        for (int i = 0; i < RUN_CYCLES; i++) begin
            jump_cond = 1'($urandom);
            rst = (($urandom % 97) == 0);
            cycle();
        end
        rst = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (RUN_CYCLES * 3) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule